// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a bank of interrupt sources and decides when each source hands an interrupt to a downstream presenter. Each source is fixed at build time as either level-sensitive or message-signalled. At run time each source is given a target server and a priority, and a priority of all ones masks it. The block keeps enough flags per source that an interrupt which is refused, or which arrives while masked, is not lost. It is delivered again later when a resend is requested or when the source is unmasked.

Each source has a local index inside the bank. On the delivery port and on the reject and end-of-interrupt inputs, a source is named by a global number, which is its local index plus a base offset. Deliveries leave through a single valid/ready port, one at a time. When several sources want the port in the same cycle, the lowest local index goes first. A resend request walks the bank one source per cycle.

Top module: `isc_source_bank`

## Requirements
- R1: After reset every source is masked (priority 0xFF) and all of its flags are clear, while its level or message type, given by the LEVEL_MASK parameter (bit i set means level-sensitive), is kept. A message trigger in this state delivers nothing.
- R2: A message source that is triggered (its `src_in` bit high for one cycle) while unmasked delivers once, with number BASE plus its local index and with its configured server and priority.
- R3: A message trigger while masked sets the masked-pending flag. A later configuration write that unmasks the source clears that flag and delivers exactly once.
- R4: A level source delivers once when its line is high, it is unmasked and its sent flag is clear. It then sets sent, and a line that stays high does not deliver again.
- R5: A reject naming a level source clears its sent flag without delivering. A later resend request delivers again if the line is still high.
- R6: A reject naming a message source sets its rejected flag. A resend request clears the flag and delivers once if the source is unmasked. A second resend delivers nothing. A masked rejected source loses the flag on resend and is not delivered when it is unmasked later.
- R7: An end-of-interrupt naming a level source clears its sent flag, so the next rise of the line delivers. An end-of-interrupt on its own delivers nothing, and one naming a message source has no effect.
- R8: Reject and end-of-interrupt numbers below BASE or at or above BASE plus NUM_SRC are ignored, including numbers whose low bits match a source's index.
- R9: A configuration write to a level source applies the level delivery rule, so unmasking a source whose line is already high delivers it.
- R10: Only one delivery is offered at a time. While `dlv_ready` is low, the offered delivery holds steady. Requests from several sources are delivered lowest index first, each once.
- R11: A resend request visits one source per cycle and finishes a full pass of the bank within NUM_SRC cycles.
- R12: A source masked by a configuration write while its delivery is still waiting for the port does not deliver. A waiting message source becomes masked-pending instead, and a waiting level source has its sent flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Level line or one-cycle trigger pulse, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority (all ones masks) |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend pass over the bank |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Presenter accepts the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_num | output | NUM_W | Global source number of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivery |

## Verification
The case that is hardest to reach from the ports is a source being masked while its request is queued behind a stalled delivery. To get there, the bench holds `dlv_ready` low, triggers one source to occupy the output, and triggers a second source so that its request is left waiting. It then masks the second source with a configuration write and releases the port. The bench checks that only the first source comes out and that unmasking later brings the second one back. Reject and end-of-interrupt aliasing is covered with out-of-range numbers whose low bits equal a live source's index, followed by a resend that would show any stray flag change.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef struct packed {
        logic asserted;   // level: last sampled line value
        logic sent;       // level: delivered, waiting for completion
        logic rejected;   // message: refused by the presenter
        logic mpend;      // message: triggered while masked
        logic req;        // waiting for the delivery port
    } src_flags_t;

    localparam src_flags_t FLAGS_CLEAR = '0;

endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell
    import isc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SRV_W    = 8,
    parameter int PRIO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              scan_hit,
    input  logic              grant,
    output logic              req,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio
);

    localparam logic [PRIO_W-1:0] MASKED = '1;

    typedef struct packed {
        logic [SRV_W-1:0]  server;
        logic [PRIO_W-1:0] prio;
        src_flags_t        fl;
    } cell_t;

    cell_t q, d;
    logic  eval;

    always_comb begin
        d    = q;
        eval = 1'b0;

        if (grant) begin
            d.fl.req = 1'b0;
        end

        // completion side
        if (IS_LEVEL) begin
            if (rej_hit || eoi_hit) begin
                d.fl.sent = 1'b0;
            end
        end else if (rej_hit) begin
            d.fl.rejected = 1'b1;
        end

        // configuration
        if (cfg_hit) begin
            d.server = cfg_server;
            d.prio   = cfg_prio;
            if (IS_LEVEL) begin
                eval = 1'b1;
            end else if (d.fl.mpend && (cfg_prio != MASKED)) begin
                d.fl.mpend = 1'b0;
                d.fl.req   = 1'b1;
            end
        end

        // input line or pulse
        if (IS_LEVEL) begin
            if (line != q.fl.asserted) begin
                d.fl.asserted = line;
                eval          = 1'b1;
            end
        end else if (line) begin
            if (d.prio == MASKED) begin
                d.fl.mpend = 1'b1;
            end else begin
                d.fl.req = 1'b1;
            end
        end

        // resend visit
        if (scan_hit) begin
            if (IS_LEVEL) begin
                eval = 1'b1;
            end else if (d.fl.rejected) begin
                d.fl.rejected = 1'b0;
                if (d.prio != MASKED) begin
                    d.fl.req = 1'b1;
                end
            end
        end

        // level delivery rule
        if (IS_LEVEL && eval && (d.prio != MASKED) && d.fl.asserted && !d.fl.sent) begin
            d.fl.sent = 1'b1;
            d.fl.req  = 1'b1;
        end

        // a waiting request whose source became masked is withdrawn
        if (d.fl.req && (d.prio == MASKED)) begin
            d.fl.req = 1'b0;
            if (IS_LEVEL) begin
                d.fl.sent = 1'b0;
            end else begin
                d.fl.mpend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.server <= '0;
            q.prio   <= MASKED;
            q.fl     <= FLAGS_CLEAR;
        end else begin
            q <= d;
        end
    end

    assign req    = q.fl.req;
    assign server = q.server;
    assign prio   = q.prio;

endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [NUM_SRC-1:0] visit
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] ptr;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d     = q;
        visit = '0;
        if (q.active) begin
            visit[q.ptr] = 1'b1;
            if (q.ptr == IDX_W'(NUM_SRC - 1)) begin
                d.active = 1'b0;
                d.ptr    = '0;
            end else begin
                d.ptr = q.ptr + 1'b1;
            end
        end else if (start) begin
            d.active = 1'b1;
            d.ptr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic               en,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        grant = '0;
        if (en && any) begin
            grant[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/isc_source_bank.sv
module isc_source_bank #(
    parameter int                 NUM_SRC    = 8,
    parameter int                 SRV_W      = 8,
    parameter int                 PRIO_W     = 8,
    parameter int                 NUM_W      = 24,
    parameter int                 BASE       = 'h1000,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int                IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [SRV_W-1:0]   dlv_server,
    output logic [NUM_W-1:0]   dlv_num,
    output logic [PRIO_W-1:0]  dlv_prio
);

    localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] SPAN_N = NUM_W'(NUM_SRC);

    typedef struct packed {
        logic              valid;
        logic [SRV_W-1:0]  server;
        logic [NUM_W-1:0]  num;
        logic [PRIO_W-1:0] prio;
    } dlv_t;

    dlv_t out_q, out_d;

    logic [NUM_SRC-1:0] cfg_hit, rej_hit, eoi_hit, visit, req, grant;
    logic [SRV_W-1:0]   srv_arr  [NUM_SRC];
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    logic [NUM_W-1:0]   rej_off, eoi_off;
    logic               rej_in, eoi_in, load, any;
    logic [IDX_W-1:0]   pick_idx;

    // global number to local index
    assign rej_off = rej_num - BASE_N;
    assign eoi_off = eoi_num - BASE_N;
    assign rej_in  = rej_valid && (rej_num >= BASE_N) && (rej_off < SPAN_N);
    assign eoi_in  = eoi_valid && (eoi_num >= BASE_N) && (eoi_off < SPAN_N);

    isc_resend_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (resend_req),
        .visit (visit)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign cfg_hit[g] = cfg_we && (cfg_idx == IDX_W'(g));
        assign rej_hit[g] = rej_in && (rej_off == NUM_W'(g));
        assign eoi_hit[g] = eoi_in && (eoi_off == NUM_W'(g));

        isc_src_cell #(
            .IS_LEVEL (LEVEL_MASK[g]),
            .SRV_W    (SRV_W),
            .PRIO_W   (PRIO_W)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .line       (src_in[g]),
            .cfg_hit    (cfg_hit[g]),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .rej_hit    (rej_hit[g]),
            .eoi_hit    (eoi_hit[g]),
            .scan_hit   (visit[g]),
            .grant      (grant[g]),
            .req        (req[g]),
            .server     (srv_arr[g]),
            .prio       (prio_arr[g])
        );
    end

    assign load = !out_q.valid || dlv_ready;

    isc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req   (req),
        .en    (load),
        .any   (any),
        .idx   (pick_idx),
        .grant (grant)
    );

    always_comb begin
        out_d = out_q;
        if (load) begin
            out_d.valid = any;
            if (any) begin
                out_d.server = srv_arr[pick_idx];
                out_d.num    = BASE_N + NUM_W'(pick_idx);
                out_d.prio   = prio_arr[pick_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dlv_valid  = out_q.valid;
    assign dlv_server = out_q.server;
    assign dlv_num    = out_q.num;
    assign dlv_prio   = out_q.prio;

endmodule

// File: rtl/isc_source_bank_chk.sv
module isc_source_bank_chk #(
    parameter int NUM_SRC = 8,
    parameter int SRV_W   = 8,
    parameter int PRIO_W  = 8,
    parameter int NUM_W   = 24,
    parameter int BASE    = 'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dlv_valid,
    input logic              dlv_ready,
    input logic [SRV_W-1:0]  dlv_server,
    input logic [NUM_W-1:0]  dlv_num,
    input logic [PRIO_W-1:0] dlv_prio
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dlv_valid); // R1

    AST_NUM_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_num >= NUM_W'(BASE)) && (dlv_num < NUM_W'(BASE + NUM_SRC))); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num)
                                    && $stable(dlv_server) && $stable(dlv_prio)); // R10

    AST_NEVER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != {PRIO_W{1'b1}})); // R12

endmodule

bind isc_source_bank isc_source_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .SRV_W   (SRV_W),
    .PRIO_W  (PRIO_W),
    .NUM_W   (NUM_W),
    .BASE    (BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_server (dlv_server),
    .dlv_num    (dlv_num),
    .dlv_prio   (dlv_prio)
);

// File: tb/isc_source_bank_test.sv
`timescale 1ns/1ps
module isc_source_bank_test;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0]    cfg_server = '0;
    logic [7:0]    cfg_prio = '0;
    logic          rej_valid = 1'b0;
    logic [23:0]   rej_num = '0;
    logic          eoi_valid = 1'b0;
    logic [23:0]   eoi_num = '0;
    logic          resend_req = 1'b0;
    logic          dlv_valid;
    logic          dlv_ready = 1'b1;
    logic [7:0]    dlv_server;
    logic [23:0]   dlv_num;
    logic [7:0]    dlv_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // accepted-delivery log
    logic [23:0] log_num [64];
    logic [7:0]  log_srv [64];
    logic [7:0]  log_pri [64];
    int log_n  = 0;
    int log_rd = 0;

    always #10 clk = ~clk;

    isc_source_bank uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio)
    );

    always @(posedge clk) begin
        if (rst_n && dlv_valid && dlv_ready && log_n < 64) begin
            log_num[log_n] <= dlv_num;
            log_srv[log_n] <= dlv_server;
            log_pri[log_n] <= dlv_prio;
            log_n          <= log_n + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int pri);
        cfg_idx = IW'(idx); cfg_server = 8'(srv); cfg_prio = 8'(pri); cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int idx);
        src_in[idx] = 1'b1;
        tick(1);
        src_in[idx] = 1'b0;
    endtask

    task automatic reject(input int num);
        rej_num = 24'(num); rej_valid = 1'b1;
        tick(1);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_num = 24'(num); eoi_valid = 1'b1;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic resend();
        resend_req = 1'b1;
        tick(1);
        resend_req = 1'b0;
        tick(N + 1);
    endtask

    task automatic expect_count(input string req, input int n);
        tick(5);
        check(req, "delivery count", log_n - log_rd, n);
    endtask

    task automatic expect_entry(input string req, input int k, input int num, input int srv, input int pri);
        check(req, "number", int'(log_num[log_rd + k]), num);
        check(req, "server", int'(log_srv[log_rd + k]), srv);
        check(req, "priority", int'(log_pri[log_rd + k]), pri);
    endtask

    task automatic consume();
        log_rd = log_n;
    endtask

    task automatic t_reset();
        check("R1", "valid after reset", int'(dlv_valid), 0);
        pulse(0);
        src_in[4] = 1'b1;
        expect_count("R1", 0);
        src_in[4] = 1'b0;
        tick(2);
        consume();
    endtask

    task automatic t_masked_pending();
        // src0 was triggered while masked during t_reset
        cfg(0, 3, 5);
        expect_count("R3", 1);
        expect_entry("R3", 0, 'h1000, 3, 5);
        consume();
        cfg(0, 3, 6);
        expect_count("R3", 0);
    endtask

    task automatic t_msg();
        cfg(1, 2, 4);
        pulse(1);
        expect_count("R2", 1);
        expect_entry("R2", 0, 'h1001, 2, 4);
        consume();
        pulse(1);
        tick(2);
        pulse(1);
        expect_count("R2", 2);
        consume();
    endtask

    task automatic t_level();
        cfg(4, 1, 6);
        expect_count("R4", 0);
        src_in[4] = 1'b1;
        tick(10);
        expect_count("R4", 1);
        expect_entry("R4", 0, 'h1004, 1, 6);
        consume();
        src_in[4] = 1'b0; tick(2); src_in[4] = 1'b1;
        expect_count("R7", 0);
        eoi('h1004);
        expect_count("R7", 0);
        src_in[4] = 1'b0; tick(2); src_in[4] = 1'b1;
        expect_count("R7", 1);
        consume();
        eoi('h1001);
        expect_count("R7", 0);
        reject('h1004);
        expect_count("R5", 0);
        resend();
        expect_count("R5", 1);
        expect_entry("R5", 0, 'h1004, 1, 6);
        consume();
    endtask

    task automatic t_range();
        reject('h100C);
        reject('hFFFFFC);
        eoi('h100C);
        eoi('h0FFC);
        reject('h0FFF);
        resend();
        expect_count("R8", 0);
    endtask

    task automatic t_msg_reject();
        reject('h1001);
        expect_count("R6", 0);
        resend();
        expect_count("R6", 1);
        expect_entry("R6", 0, 'h1001, 2, 4);
        consume();
        resend();
        expect_count("R6", 0);
        reject('h1001);
        cfg(1, 2, 'hFF);
        resend();
        cfg(1, 2, 4);
        expect_count("R6", 0);
    endtask

    task automatic t_resend_pass();
        // reject sources 0 and 1 and check both come back within one pass
        reject('h1000);
        reject('h1001);
        resend_req = 1'b1;
        tick(1);
        resend_req = 1'b0;
        tick(N + 2);
        check("R11", "deliveries after one pass", log_n - log_rd, 2);
        consume();
    endtask

    task automatic t_level_cfg();
        src_in[5] = 1'b1;
        expect_count("R9", 0);
        cfg(5, 7, 2);
        expect_count("R9", 1);
        expect_entry("R9", 0, 'h1005, 7, 2);
        consume();
    endtask

    task automatic t_order_stall();
        dlv_ready = 1'b0;
        cfg(2, 1, 3);
        cfg(3, 0, 1);
        src_in[2] = 1'b1; src_in[3] = 1'b1;
        tick(1);
        src_in[2] = 1'b0; src_in[3] = 1'b0;
        tick(3);
        check("R10", "valid while stalled", int'(dlv_valid), 1);
        check("R10", "offered number", int'(dlv_num), 'h1002);
        tick(4);
        check("R10", "number held", int'(dlv_num), 'h1002);
        check("R10", "nothing accepted", log_n - log_rd, 0);
        dlv_ready = 1'b1;
        expect_count("R10", 2);
        expect_entry("R10", 0, 'h1002, 1, 3);
        expect_entry("R10", 1, 'h1003, 0, 1);
        consume();
    endtask

    task automatic t_mask_waiting();
        dlv_ready = 1'b0;
        pulse(1);
        tick(2);
        pulse(2);
        tick(1);
        cfg(2, 1, 'hFF);
        dlv_ready = 1'b1;
        expect_count("R12", 1);
        expect_entry("R12", 0, 'h1001, 2, 4);
        consume();
        cfg(2, 1, 3);
        expect_count("R12", 1);
        expect_entry("R12", 0, 'h1002, 1, 3);
        consume();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_masked_pending();
        t_msg();
        t_level();
        t_range();
        t_msg_reject();
        t_resend_pass();
        t_level_cfg();
        t_order_stall();
        t_mask_waiting();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule